// File: doc/BRIEF.md
# Multichannel PWM Phase Synchronizer

This block generates the period timing for a bank of eight pulse-width channels that share one clock. A rising edge on an asynchronous sync input restarts every channel at the same moment. Each channel then waits its own programmed phase delay before it opens a new period. The delay is set in steps of one thirty-second of the PWM period. Within each period, a channel's output stays high for the number of clock cycles held in its duty register. A sticky flag records that a sync pulse arrived and clears when the host reads it.

A host programs the block over a plain parallel write port. It programs the period length, and for each channel a duty value, a phase offset and a hold policy that decides what the channel does while the global enable is low. After reset the channels stay idle. They carry no phase relation until the first sync edge arrives.

Top module: `pwm_phase_sync`

## Requirements
- R1: `sync_in` passes through two synchronizing flops and a rising-edge detector. Count the first rising clock edge at which `sync_in` is high as edge 1. A channel with phase offset 0 (and nonzero duty) is then first seen high after edge 5. Every channel restarts on the same detected edge, and its output is low while it waits out its offset.
- R2: A channel with offset value k (register address 16+channel, bits 4:0) first goes high k × U cycles later than a channel with offset 0. U is the period unit count of R3.
- R3: Address 0, bits 6:0, holds the period unit count U, so the period is U × 32 clock cycles. A write of 0 to this register is ignored and the old value is kept.
- R4: The duty register of a channel is at address 8+channel, bits 11:0. In every period the output is high for the first `duty` cycles. A duty of 0 never drives the output high, and a duty of at least the period length keeps the output high for the whole period.
- R5: `stat_flag` goes to 1 one cycle after a detected sync edge. A cycle with `stat_rd` high clears it. When a sync edge and a read fall in the same cycle, the flag stays 1.
- R6: While `rst_n` is low, `pwm_out` and `stat_flag` are 0. Reset restores U = 4, and every duty, offset and hold bit to 0.
- R7: After reset, no channel output goes high before the first sync edge, whatever the duty registers hold.
- R8: Address 1, bit i, is the hold policy of channel i. While `enable` is low, a channel whose bit is 0 drives 0 from the next cycle on, and a channel whose bit is 1 keeps its last output. Channel timing keeps running, so raising `enable` again restores the normal output one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; all timing derives from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global output enable, active high |
| sync_in | input | 1 | Asynchronous phase sync request, rising edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| stat_rd | input | 1 | Status read; clears the sync flag |
| stat_flag | output | 1 | Sticky flag: sync edge received |
| pwm_out | output | 8 | Channel outputs |

## Verification
The assertions assume that `sync_in` pulses are separated by far more than the synchronizer depth. They also assume that the period unit, duty and offset values do not change while a channel is counting out its offset delay. The stimulus respects both assumptions. It holds each sync pulse for three cycles and then waits at least one full period. It rewrites configuration only outside the scoreboard windows that follow a sync edge. The checks that follow a sync edge compare rise times only inside a window shorter than one period, so the regular rises of later periods do not enter the comparison.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  localparam int unsigned SLOT_CNT = 32;
  localparam int unsigned SLOT_W   = 5;

  // length of one period in clock cycles for a unit count
  function automatic int unsigned period_cycles(input int unsigned units);
    return units * SLOT_CNT;
  endfunction

  // delay from restart to period start in clock cycles
  function automatic int unsigned offset_cycles(input int unsigned ofs,
                                                input int unsigned units);
    return ofs * units;
  endfunction
endpackage

// File: rtl/pwm_sync_edge.sv
module pwm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  // R1
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pwm_sync_regs.sv
module pwm_sync_regs #(
  parameter int NCH       = 8,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int UNIT_W    = 7,
  parameter int CNT_W     = 12,
  parameter int OFS_W     = 5,
  parameter int DEF_UNITS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [UNIT_W-1:0]      units,
  output logic [NCH-1:0]         hold_mask,
  output logic [NCH*CNT_W-1:0]   duty_flat,
  output logic [NCH*OFS_W-1:0]   ofs_flat
);
  localparam int PERIOD_ADDR = 0;
  localparam int HOLD_ADDR   = 1;
  localparam int DUTY_BASE   = 8;
  localparam int OFS_BASE    = 16;

  logic hit_period, hit_hold, unit_zero;
  assign hit_period = wr_en && (wr_addr == ADDR_W'(PERIOD_ADDR));
  assign hit_hold   = wr_en && (wr_addr == ADDR_W'(HOLD_ADDR));
  assign unit_zero  = (wr_data[UNIT_W-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      units     <= UNIT_W'(DEF_UNITS);
      hold_mask <= '0;
    end else begin
      if (hit_period && !unit_zero) units <= wr_data[UNIT_W-1:0];
      if (hit_hold) hold_mask <= wr_data[NCH-1:0];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit_duty, hit_ofs;
    assign hit_duty = wr_en && (wr_addr == ADDR_W'(DUTY_BASE + g));
    assign hit_ofs  = wr_en && (wr_addr == ADDR_W'(OFS_BASE + g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        duty_flat[g*CNT_W +: CNT_W] <= '0;
        ofs_flat[g*OFS_W +: OFS_W]  <= '0;
      end else begin
        if (hit_duty) duty_flat[g*CNT_W +: CNT_W] <= wr_data[CNT_W-1:0];
        if (hit_ofs)  ofs_flat[g*OFS_W +: OFS_W]  <= wr_data[OFS_W-1:0];
      end
    end
  end

  // R3
  zero_unit_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_period && unit_zero) |=> $stable(units));
endmodule

// File: rtl/pwm_sync_chan.sv
module pwm_sync_chan
  import pwm_sync_pkg::*;
#(
  parameter int UNIT_W = 7,
  parameter int CNT_W  = 12,
  parameter int OFS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              enable,
  input  logic              hold,
  input  logic [UNIT_W-1:0] units,
  input  logic [CNT_W-1:0]  duty,
  input  logic [OFS_W-1:0]  ofs,
  output logic              pwm
);
  logic             waiting, running, raw, start;
  logic [CNT_W-1:0] wait_cnt, phase_cnt, period_len, delay_len;

  assign period_len = CNT_W'(period_cycles(32'(units)));
  assign delay_len  = CNT_W'(offset_cycles(32'(ofs), 32'(units)));
  assign start      = waiting && (wait_cnt == '0) && !restart;
  assign raw        = running && (phase_cnt < duty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting   <= 1'b0;
      running   <= 1'b0;
      wait_cnt  <= '0;
      phase_cnt <= '0;
    end else if (restart) begin
      waiting   <= 1'b1;
      running   <= 1'b0;
      wait_cnt  <= delay_len;
      phase_cnt <= '0;
    end else if (waiting) begin
      if (wait_cnt == '0) begin
        waiting   <= 1'b0;
        running   <= 1'b1;
        phase_cnt <= '0;
      end else begin
        wait_cnt <= wait_cnt - 1'b1;
      end
    end else if (running) begin
      phase_cnt <= (phase_cnt >= period_len - 1'b1) ? '0 : phase_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pwm <= 1'b0;
    else if (enable) pwm <= raw;
    else if (!hold)  pwm <= 1'b0;
  end

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && phase_cnt == '0));
  // R1
  restart_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!running && waiting));
endmodule

// File: rtl/pwm_phase_sync.sv
module pwm_phase_sync #(
  parameter int NCH       = 8,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int UNIT_W    = 7,
  parameter int OFS_W     = 5,
  parameter int SYNC_FF   = 2,
  parameter int DEF_UNITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sync_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_rd,
  output logic              stat_flag,
  output logic [NCH-1:0]    pwm_out
);
  localparam int CNT_W = UNIT_W + OFS_W;

  logic                 sync_edge;
  logic [UNIT_W-1:0]    units;
  logic [NCH-1:0]       hold_mask;
  logic [NCH*CNT_W-1:0] duty_flat;
  logic [NCH*OFS_W-1:0] ofs_flat;

  pwm_sync_edge #(.STAGES(SYNC_FF)) u_edge (
    .clk(clk), .rst_n(rst_n), .async_in(sync_in), .rise(sync_edge)
  );

  pwm_sync_regs #(
    .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNIT_W(UNIT_W),
    .CNT_W(CNT_W), .OFS_W(OFS_W), .DEF_UNITS(DEF_UNITS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .units(units), .hold_mask(hold_mask),
    .duty_flat(duty_flat), .ofs_flat(ofs_flat)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pwm_sync_chan #(.UNIT_W(UNIT_W), .CNT_W(CNT_W), .OFS_W(OFS_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .restart(sync_edge), .enable(enable),
      .hold(hold_mask[g]), .units(units),
      .duty(duty_flat[g*CNT_W +: CNT_W]), .ofs(ofs_flat[g*OFS_W +: OFS_W]),
      .pwm(pwm_out[g])
    );

    // R8
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !hold_mask[g]) |=> !pwm_out[g]);
    // R8
    hold_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && hold_mask[g]) |=> $stable(pwm_out[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stat_flag <= 1'b0;
    else if (sync_edge) stat_flag <= 1'b1;
    else if (stat_rd)   stat_flag <= 1'b0;
  end

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_edge |=> stat_flag);
  // R5
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !sync_edge) |=> !stat_flag);
endmodule

// File: tb/pwm_phase_sync_test.sv
module pwm_phase_sync_test;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        sync_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        stat_rd = 1'b0;
  logic        stat_flag;
  logic [NCH-1:0] pwm_out;

  int checks = 0, failures = 0;
  longint cyc = 0;
  longint sb_lo = -1, sb_hi = -1;
  int exp_ch[$];
  longint exp_cyc[$];
  logic [NCH-1:0] prev_out = '0;
  bit done = 0;

  pwm_phase_sync uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_in(sync_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stat_rd(stat_rd), .stat_flag(stat_flag), .pwm_out(pwm_out)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected first rises during a scoreboard window
  always @(negedge clk) begin
    if (cyc >= sb_lo && cyc <= sb_hi) begin
      for (int c = 0; c < NCH; c++) begin
        if (pwm_out[c] && !prev_out[c]) begin
          checks++;
          if (exp_ch.size() == 0) begin
            failures++;
            $display("FAIL R2 unexpected rise ch=%0d actual=%0d expected=none", c, cyc);
          end else begin
            int ec;
            longint et;
            ec = exp_ch.pop_front();
            et = exp_cyc.pop_front();
            if (ec != c || et != cyc) begin
              failures++;
              $display("FAIL R1/R2 rise actual ch=%0d cyc=%0d expected ch=%0d cyc=%0d",
                       c, cyc, ec, et);
            end
          end
        end
      end
    end
    prev_out = pwm_out;
  end

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(addr); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: fires a sync pulse, queues expected first rises
  task automatic sync_run(input int units, input int ofs[NCH]);
    longint t0;
    @(negedge clk);
    sync_in = 1'b1;
    t0 = cyc + 1;
    for (int d = 0; d < 32; d++)
      for (int c = 0; c < NCH; c++)
        if (ofs[c] == d) begin
          exp_ch.push_back(c);
          exp_cyc.push_back(t0 + 4 + longint'(d) * units);
        end
    sb_lo = t0 + 3;
    sb_hi = t0 + 2 + units * 32;
    wait_cyc(3);
    sync_in = 1'b0;
    while (cyc <= sb_hi) @(negedge clk);
    chk("R2 pending rises", exp_ch.size(), 0);
    exp_ch.delete();
    exp_cyc.delete();
  endtask

  task automatic rise_gap(input int c, output longint gap);
    longint t1;
    logic p;
    p = pwm_out[c];
    forever begin @(negedge clk); if (pwm_out[c] && !p) break; p = pwm_out[c]; end
    t1 = cyc;
    p = 1'b1;
    forever begin @(negedge clk); if (pwm_out[c] && !p) break; p = pwm_out[c]; end
    gap = cyc - t1;
  endtask

  initial begin
    int ofs_a[NCH];
    int ofs_b[NCH];
    int hi_cnt[3];
    longint gap;
    logic held;
    bit stable_ok;

    // R6 reset state
    wait_cyc(4);
    chk("R6 pwm in reset", pwm_out, 0);
    chk("R6 flag in reset", stat_flag, 0);
    @(negedge clk); rst_n = 1'b1; enable = 1'b1;
    wait_cyc(2);
    chk("R6 pwm after reset", pwm_out, 0);

    // R7 no output before first sync
    for (int c = 0; c < NCH; c++) wr(8 + c, 10);
    wait_cyc(300);
    chk("R7 idle before sync", pwm_out, 0);
    chk("R5 flag idle", stat_flag, 0);

    // R1 default offsets and default units (R6)
    for (int c = 0; c < NCH; c++) ofs_a[c] = 0;
    sync_run(4, ofs_a);
    chk("R5 flag after sync", stat_flag, 1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk("R5 flag cleared", stat_flag, 0);

    // R2 distinct offsets, U=8
    wr(0, 8);
    ofs_a = '{0, 3, 31, 7, 7, 16, 1, 24};
    for (int c = 0; c < NCH; c++) wr(16 + c, ofs_a[c]);
    sync_run(8, ofs_a);

    // R1 restart while running, other offsets
    ofs_b = '{30, 0, 5, 12, 2, 29, 18, 9};
    for (int c = 0; c < NCH; c++) wr(16 + c, ofs_b[c]);
    sync_run(8, ofs_b);

    // R4 duty 0 / 10 / beyond period
    wr(8, 0); wr(10, 300);
    wait_cyc(300);
    hi_cnt = '{0, 0, 0};
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      for (int c = 0; c < 3; c++) if (pwm_out[c]) hi_cnt[c]++;
    end
    chk("R4 duty 0", hi_cnt[0], 0);
    chk("R4 duty 10", hi_cnt[1], 10);
    chk("R4 duty over period", hi_cnt[2], 256);

    // R3 period change and ignored zero write
    wr(0, 5);
    wait_cyc(400);
    rise_gap(1, gap);
    chk("R3 period U=5", gap, 160);
    wr(0, 0);
    wait_cyc(50);
    rise_gap(1, gap);
    chk("R3 zero write ignored", gap, 160);

    // R8 enable gating with hold policy
    wr(8, 4095); wr(9, 4095); wr(10, 0);
    wr(1, 8'b0000_1110);
    wait_cyc(200);
    held = pwm_out[3];
    @(negedge clk); enable = 1'b0;
    held = pwm_out[3];
    wait_cyc(2);
    chk("R8 off policy ch0", pwm_out[0], 0);
    chk("R8 hold high ch1", pwm_out[1], 1);
    chk("R8 hold low ch2", pwm_out[2], 0);
    stable_ok = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pwm_out[3] !== held) stable_ok = 0;
    end
    chk("R8 hold stable ch3", stable_ok, 1);
    @(negedge clk); enable = 1'b1;
    wait_cyc(2);
    chk("R8 resume ch0", pwm_out[0], 1);

    // R5 sync edge and read in the same cycle
    @(negedge clk); sync_in = 1'b1;   // edge A next
    @(negedge clk);                    // after A
    @(negedge clk); stat_rd = 1'b1;   // after B: edge detected this cycle
    @(negedge clk); stat_rd = 1'b0;   // after C
    chk("R5 flag kept on collision", stat_flag, 1);
    sync_in = 1'b0;
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk("R5 flag cleared after collision", stat_flag, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule